// File: doc/BRIEF.md
# Presence-Detect Memory Serial Target

This block is the target side of a two-wire serial bus (I2C/SMBus) in front of a 512-byte configuration memory, such as the one on a memory module. A controller uses it to read the module's description bytes, and it can also write those bytes. The block runs from a fast system clock and oversamples SCL and SDA. It pulls SDA low through an output-enable and never drives it high. It does not stretch the clock.

Three slot-select pins set the low three bits of two address groups: the memory group and a temperature-sensor group. The sensor group is acknowledged but has nothing behind it. A third group holds bus-wide command addresses, which ignore the slot pins. These commands pick which 256-byte page later accesses see, and they set or clear write protection. Protection is kept for each 128-byte block.

A write transfer carries a byte offset and then data bytes. A read transfer, which may follow a repeated START, returns bytes from the current offset. In both directions the offset advances after each byte and wraps inside the page.

Top module: `pd_eeprom_target`

## Requirements
- R1: A 7-bit address of 1010 followed by the slot pins (bit 2 down to 0) is acknowledged. A memory-group address with any other low bits is not acknowledged.
- R2: A 7-bit address of 0011 followed by the slot pins is acknowledged. Data bytes written to it are acknowledged and change neither the memory nor the current offset. Every byte read from it is 0xFF.
- R3: Any address outside the recognised groups gets no acknowledge. The target then leaves SDA released until the next START.
- R4: In a memory write, the first byte after the address sets the 8-bit offset. Each later byte is stored at {page, offset}, and the offset then increments, wrapping from 0xFF to 0x00 within the same page.
- R5: A memory read returns the byte at the current offset and increments the offset after each byte. This also holds after a repeated START that follows an offset write. After the controller NACKs a byte, the target releases SDA.
- R6: Address 0x36 selects page 0 and address 0x37 selects page 1, regardless of the slot pins. Both are acknowledged, and bytes sent after them are acknowledged and ignored. The page selection applies to all later memory accesses until it is changed.
- R7: Addresses 0x30 to 0x33 protect block 0 to 3, where block = {page, offset bit 7}. Address 0x34 clears protection on all blocks. None of these is qualified by the slot pins. Address 0x35 is not acknowledged.
- R8: A data byte written into a protected block is acknowledged and leaves that location unchanged. The offset still advances, and unprotected blocks stay writable.
- R9: After reset, SDA is released, page 0 is selected and no block is protected.
- R10: The target pulls SDA low only in acknowledge slots and in the data bits of a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock as sensed on the bus |
| sda_i | input | 1 | Serial data as sensed on the bus |
| slot_sel | input | 3 | Slot-select pins, low bits of the memory and sensor addresses |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
All 128 seven-bit addresses are swept with one slot setting, and the memory group is then crossed against every slot setting. Together these separate the three groups from the no-acknowledge space and show which addresses the slot pins qualify. Write and read bursts are placed across the 0xFF-to-0x00 wrap and across the 128-byte boundary, on both pages. The bench then compares the same offsets across the two pages to show page isolation. Protection is set with different slot pins and then tested with writes that straddle a protected and an unprotected block. Sensor-group writes and reads are followed by a current-offset read, which shows that they left the memory and the offset alone.

// File: rtl/pd_eeprom_target.sv
module pd_eeprom_target #(
  parameter logic [3:0] MEM_TYPE  = 4'b1010,
  parameter logic [3:0] TSEN_TYPE = 4'b0011,
  parameter logic [3:0] CMD_TYPE  = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] slot_sel,
  output logic       sda_oe
);
  localparam int OFF_W = 8;
  localparam int AW    = OFF_W + 1;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} st_t;

  logic [2:0] scl_sy, sda_sy;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  logic scl, scl_d, sda, sda_d, scl_r, scl_f, start_c, stop_c;
  assign scl     = scl_sy[1];
  assign scl_d   = scl_sy[2];
  assign sda     = sda_sy[1];
  assign sda_d   = sda_sy[2];
  assign scl_r   = scl & ~scl_d;
  assign scl_f   = ~scl & scl_d;
  assign start_c = scl & scl_d & sda_d & ~sda;
  assign stop_c  = scl & scl_d & ~sda_d & sda;

  st_t              st;
  logic [3:0]       cnt;
  logic [7:0]       sr;
  logic             rd, is_addr, to_mem, got_off, nack, page;
  logic [OFF_W-1:0] off;
  logic [3:0]       wp;
  logic [7:0]       mem [0:DEPTH-1];

  logic [6:0]    a7;
  logic          hit_mem, hit_tsen, hit_cmd, byte_done, prot, mem_we, load_tx;
  logic [AW-1:0] waddr;
  logic [7:0]    tx_byte;

  assign a7        = sr[7:1];
  assign hit_mem   = (a7 == {MEM_TYPE, slot_sel});
  assign hit_tsen  = (a7 == {TSEN_TYPE, slot_sel});
  assign hit_cmd   = (a7[6:3] == CMD_TYPE) && (a7[2:0] != 3'd5);
  assign byte_done = (st == S_RX) && scl_f && (cnt == 4'd8);
  assign waddr     = {page, off};
  assign prot      = wp[{page, off[OFF_W-1]}];
  assign mem_we    = byte_done && !is_addr && to_mem && got_off && !prot;
  assign tx_byte   = to_mem ? mem[waddr] : 8'hFF;
  assign load_tx   = scl_f && (((st == S_ACK) && rd) || ((st == S_RACK) && !nack));

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= sr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sr      <= '0;
      rd      <= 1'b0;
      is_addr <= 1'b0;
      to_mem  <= 1'b0;
      got_off <= 1'b0;
      nack    <= 1'b0;
      page    <= 1'b0;
      off     <= '0;
      wp      <= '0;
      sda_oe  <= 1'b0;
    end else if (start_c) begin
      st      <= S_RX;
      cnt     <= '0;
      is_addr <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (load_tx) begin
      st      <= S_TX;
      is_addr <= 1'b0;
      sr      <= tx_byte;
      sda_oe  <= ~tx_byte[7];
      cnt     <= 4'd1;
      if (to_mem) off <= off + 1'b1;
    end else begin
      case (st)
        S_RX: begin
          if (scl_r) begin
            sr  <= {sr[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (is_addr) begin
              if (hit_mem || hit_tsen || hit_cmd) begin
                st     <= S_ACK;
                sda_oe <= 1'b1;
                rd     <= sr[0];
                to_mem <= hit_mem;
                if (hit_mem && !sr[0]) got_off <= 1'b0;
                if (hit_cmd) begin
                  case (a7[2:0])
                    3'd4:    wp      <= '0;
                    3'd6:    page    <= 1'b0;
                    3'd7:    page    <= 1'b1;
                    default: wp[a7[1:0]] <= 1'b1;
                  endcase
                end
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st     <= S_ACK;
              sda_oe <= 1'b1;
              if (to_mem) begin
                if (!got_off) begin
                  off     <= sr;
                  got_off <= 1'b1;
                end else begin
                  off <= off + 1'b1;
                end
              end
            end
          end
        end
        S_ACK: if (scl_f) begin
          is_addr <= 1'b0;
          st      <= S_RX;
          sda_oe  <= 1'b0;
        end
        S_TX: if (scl_f) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            st     <= S_RACK;
          end else begin
            sr     <= {sr[6:0], 1'b0};
            sda_oe <= ~sr[6];
            cnt    <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_r) nack <= sda;
          else if (scl_f && nack) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_drive_slots_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACK || st == S_TX));

  assert_protected_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !is_addr && to_mem && got_off && prot) |=>
      (mem[$past(waddr)] == $past(mem[waddr])));

  assert_page_by_command_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (page != $past(page)) |-> ($past(byte_done) && $past(is_addr) && $past(hit_cmd)));

  assert_protect_one_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wp & ~$past(wp)) != 4'd0) |-> ($countones(wp ^ $past(wp)) == 1));
endmodule

// File: tb/pd_eeprom_target_tb_top.sv
module pd_eeprom_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] sa = 3'd5;
  logic       dut_oe;
  logic       sda;
  assign sda = !(m_low || dut_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_eeprom_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .slot_sel(sa), .sda_oe(dut_oe)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] mdl [0:511];
  logic [3:0] mwp = '0;
  logic       mpage = 1'b0;
  logic [7:0] moff = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = !sda; wq(); scl = 1'b0; wq();
  endtask

  task automatic rbyte(input bit last, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda; wq(); scl = 1'b0; wq();
    end
    m_low = !last; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    m_low = 1'b0;
  endtask

  function automatic bit exp_ack(input int a, input logic [2:0] s);
    return (a == (8'h50 | s)) || (a == (8'h18 | s)) ||
           (a >= 8'h30 && a <= 8'h37 && a != 8'h35);
  endfunction

  task automatic model_cmd(input int a);
    if (a == 8'h34) mwp = '0;
    else if (a == 8'h36) mpage = 1'b0;
    else if (a == 8'h37) mpage = 1'b1;
    else if (a >= 8'h30 && a <= 8'h33) mwp[a - 8'h30] = 1'b1;
  endtask

  task automatic cmd(input int a, input string req);
    bit ack;
    i2c_start(); wbyte(8'(a << 1), ack); i2c_stop();
    chk(req, ack, 1);
    model_cmd(a);
  endtask

  task automatic mem_write(input logic [7:0] o0, input int n, input logic [7:0] seed, input string req);
    bit ack;
    logic [7:0] o, d;
    o = o0;
    i2c_start();
    wbyte({4'b1010, sa, 1'b0}, ack); chk(req, ack, 1);
    wbyte(o0, ack); chk(req, ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      wbyte(d, ack); chk(req, ack, 1);
      if (!mwp[{mpage, o[7]}]) mdl[{mpage, o}] = d;
      o = o + 8'd1;
    end
    i2c_stop();
    moff = o;
  endtask

  task automatic mem_read(input logic [7:0] o0, input int n, input string req);
    bit ack;
    logic [7:0] o, b;
    o = o0;
    i2c_start();
    wbyte({4'b1010, sa, 1'b0}, ack); chk(req, ack, 1);
    wbyte(o0, ack); chk(req, ack, 1);
    i2c_start();
    wbyte({4'b1010, sa, 1'b1}, ack); chk(req, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, b);
      chk(req, b, mdl[{mpage, o}]);
      o = o + 8'd1;
    end
    chk("R5 released after NACK", dut_oe, 0);
    i2c_stop();
    moff = o;
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wq();
    chk("R9 SDA released after reset", dut_oe, 0);
    chk("R9 bus high after reset", sda, 1);
    mem_write(8'h40, 2, 8'h21, "R9 write after reset");

    for (int a = 0; a < 128; a++) begin
      i2c_start(); wbyte(8'(a << 1), ack); i2c_stop();
      if (a == (8'h50 | sa)) chk("R1 address sweep", ack, 1);
      else if (a == (8'h18 | sa)) chk("R2 address sweep", ack, 1);
      else if (a >= 8'h30 && a <= 8'h37) chk("R7 command sweep", ack, exp_ack(a, sa));
      else chk("R3 address sweep", ack, 0);
      model_cmd(a);
      chk("R3 released after address", dut_oe, 0);
    end

    for (int s = 0; s < 8; s++) begin
      sa = 3'(s);
      for (int g = 0; g < 8; g++) begin
        i2c_start(); wbyte(8'((8'h50 | g) << 1), ack); i2c_stop();
        chk("R1 slot cross", ack, (g == s) ? 1 : 0);
      end
    end
    sa = 3'd5;

    cmd(8'h36, "R6 select page 0");
    mem_read(8'h40, 2, "R9 reset page was 0");
    mem_write(8'hFC, 8, 8'h11, "R4 wrap write");
    mem_read(8'hFC, 8, "R4 wrap read");

    cmd(8'h37, "R6 select page 1");
    mem_write(8'hFC, 4, 8'hA0, "R6 page 1 write");
    mem_write(8'h7E, 4, 8'h30, "R4 page 1 block edge");
    mem_read(8'hFC, 4, "R6 page 1 read");
    cmd(8'h36, "R6 back to page 0");
    mem_read(8'hFC, 4, "R6 page 0 isolated");

    i2c_start();
    wbyte(8'h6E, ack); chk("R6 page select ack", ack, 1);
    wbyte(8'h00, ack); chk("R6 trailing byte", ack, 1);
    wbyte(8'h6C, ack); chk("R6 trailing byte", ack, 1);
    i2c_stop();
    mpage = 1'b1;
    mem_read(8'hFC, 4, "R6 trailing bytes ignored");
    cmd(8'h36, "R6 select page 0");

    sa = 3'd2;
    cmd(8'h31, "R7 protect block 1 other slot");
    sa = 3'd5;
    mem_write(8'hFE, 4, 8'h55, "R8 straddle write");
    mem_read(8'hFE, 4, "R8 protected unchanged");

    cmd(8'h37, "R6 select page 1");
    cmd(8'h32, "R7 protect block 2");
    mem_write(8'h7E, 4, 8'h77, "R8 page 1 straddle");
    mem_read(8'h7E, 4, "R8 page 1 check");

    cmd(8'h34, "R7 clear protection");
    cmd(8'h36, "R6 select page 0");
    mem_write(8'hFE, 2, 8'hC0, "R7 writable after clear");
    mem_read(8'hFE, 2, "R7 writable after clear");

    i2c_start();
    wbyte({4'b0011, sa, 1'b1}, ack); chk("R2 sensor read ack", ack, 1);
    rbyte(1'b1, b); chk("R2 sensor read data", b, 8'hFF);
    i2c_stop();
    i2c_start();
    wbyte({4'b0011, sa, 1'b0}, ack); chk("R2 sensor write ack", ack, 1);
    wbyte(8'h10, ack); chk("R2 sensor byte", ack, 1);
    wbyte(8'h99, ack); chk("R2 sensor byte", ack, 1);
    i2c_stop();
    i2c_start();
    wbyte({4'b1010, sa, 1'b1}, ack); chk("R5 current read ack", ack, 1);
    rbyte(1'b1, b); chk("R2 offset untouched by sensor", b, mdl[{mpage, moff}]);
    chk("R10 released after NACK", dut_oe, 0);
    i2c_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule